// File: doc/BRIEF.md
# Two-Wire Bus Address-Matching Slave

This block is a slave endpoint on an open-drain two-wire bus with a clock line and a data line. It watches both lines, finds the START and STOP conditions, and after every START it shifts in the first packet of the transfer. That packet holds a 7-bit address and a direction bit. The block then decides whether to acknowledge. It answers to a programmable own address. It can also answer the all-zero general-call address, for writes only and only when that option is enabled. It refuses the reserved 1111xxx range and it refuses every address while a local busy input is high.

Once the block is addressed for a write, it receives data bytes and passes each one to a local sink with a one-cycle strobe. A flag tells whether the byte came in through a general call. Once it is addressed for a read, it takes bytes from a local source and drives them out. It keeps doing so until the master answers a byte with a NACK.

The data-line output is an open-drain pull-low enable. It changes only while the clock line is low. Both bus inputs pass through a synchronizer before use.

Top module: `tws_slave`

## Requirements
- R1: After a synchronous reset, `sda_oe`, `rx_valid` and `tx_take` are all low.
- R2: The first byte after a START is sampled MSB first, one bit per rising clock-line edge. Bits 7..1 form the address and bit 0 gives the direction (0 = write, 1 = read). A byte whose address equals `own_addr` is acknowledged by holding `sda_oe` high through the ninth clock.
- R3: A non-matching address is not acknowledged. Bytes that follow it produce no `rx_valid` until the next START.
- R4: If `busy` is high when the eighth address bit is sampled, the address is not acknowledged, even when it matches.
- R5: In a write, each received byte appears on `rx_data` with a single-cycle `rx_valid` pulse and is acknowledged in its ninth clock.
- R6: Address 0000000 with the write bit is acknowledged only while `gc_en` is high. Bytes that follow it carry `rx_gc` = 1, and bytes sent to the own address carry `rx_gc` = 0.
- R7: Address 0000000 with the read bit is never acknowledged.
- R8: Any address whose top four bits are 1111 is never acknowledged, even when `own_addr` holds that value.
- R9: In a read, `tx_data` is captured on the clock-line falling edge that opens each byte, together with a one-cycle `tx_take` pulse. Its bits then go out MSB first (`sda_oe` = inverted bit).
- R10: After the master returns a NACK on a transmitted byte, the block releases the data line. It sends no more bits and raises no more `tx_take` until the next START.
- R11: A START or STOP seen in the middle of a packet aborts it. The partial byte is not delivered. After a START, a new address packet is decoded.
- R12: `sda_oe` is raised only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| sda_oe | output | 1 | High pulls the data line low |
| own_addr | input | 7 | Programmed own address |
| gc_en | input | 1 | Enables acknowledgment of general-call writes |
| busy | input | 1 | Local side cannot serve; forces NACK on address |
| tx_data | input | 8 | Next byte to transmit in a read |
| tx_take | output | 1 | One-cycle pulse when `tx_data` has been captured |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_gc | output | 1 | Received byte arrived through a general call |

## Verification
A wrong state in the engine shows up at the ports within one bus clock. The ninth-clock level read by the master is off, a byte strobe is missing or extra, or the bits clocked out in a read do not match the source byte. Misplaced bit counting shifts every later bit, so a byte the master reads back differs from the byte the source supplied, and it differs by the next byte at the latest. An abort that fails to clear the engine shows up as a stray acknowledge or as a delivered partial byte before the next STOP.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADEC, S_AACK,
    S_RX, S_RDEC, S_RACK, S_TX, S_TACK
  } eng_state_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [1:0] chain [STAGES];
  logic [1:0] prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 2'b11;
        else if (g == 0) chain[g] <= {scl_raw, sda_raw};
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 2'b11;
    else prev <= chain[STAGES-1];
  end

  assign scl_s    = chain[STAGES-1][1];
  assign sda_s    = chain[STAGES-1][0];
  assign scl_rise = scl_s & ~prev[1];
  assign scl_fall = ~scl_s & prev[1];
  // data edges while the clock line stays high
  assign start_p  = scl_s & prev[1] & prev[0] & ~sda_s;
  assign stop_p   = scl_s & prev[1] & ~prev[0] & sda_s;
endmodule

// File: rtl/tws_addr_dec.sv
module tws_addr_dec #(
  parameter int DATA_W   = 8,
  parameter int RSV_BITS = 4
) (
  input  logic [DATA_W-1:0] cand,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              gc_en,
  input  logic              busy,
  output logic              hit,
  output logic              is_gc
);
  localparam int AW = DATA_W - 1;
  logic [AW-1:0] addr;
  logic          rd, reserved, own_hit;

  always_comb begin
    addr     = cand[DATA_W-1:1];
    rd       = cand[0];
    reserved = &addr[AW-1:AW-RSV_BITS];
    is_gc    = (addr == '0) && !rd && gc_en;
    own_hit  = (addr == own_addr) && !reserved && (addr != '0);
    hit      = !busy && (is_gc || own_hit);
  end
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              addr_hit,
  input  logic              addr_gc,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] cand,
  output logic              sda_oe,
  output logic              tx_take,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_gc
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  eng_state_t        st;
  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              hit_q, rd_q, gc_q, mnack;

  assign cand = {sh[DATA_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sh <= '0; cnt <= '0;
      hit_q <= 1'b0; rd_q <= 1'b0; gc_q <= 1'b0; mnack <= 1'b0;
      sda_oe <= 1'b0; tx_take <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_gc <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      if (start_p) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_p) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            sh  <= cand;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              st <= S_ADEC; hit_q <= addr_hit; rd_q <= sda_s; gc_q <= addr_gc;
            end
          end
          S_ADEC: if (scl_fall) begin
            if (hit_q) begin sda_oe <= 1'b1; st <= S_AACK; end
            else st <= S_IDLE;
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rd_q) begin
              sh <= tx_data; sda_oe <= ~tx_data[DATA_W-1];
              tx_take <= 1'b1; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
            end
          end
          S_RX: if (scl_rise) begin
            sh  <= cand;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= S_RDEC;
          end
          S_RDEC: if (scl_fall) begin
            rx_data <= sh; rx_gc <= gc_q; rx_valid <= 1'b1;
            sda_oe <= 1'b1; st <= S_RACK;
          end
          S_RACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; st <= S_RX;
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0; st <= S_TACK;
              end else begin
                sh <= sh << 1; sda_oe <= ~sh[DATA_W-2];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (!mnack) begin
                sh <= tx_data; sda_oe <= ~tx_data[DATA_W-1];
                tx_take <= 1'b1; st <= S_TX;
              end else st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tws_slave.sv
module tws_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RSV_BITS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              gc_en,
  input  logic              busy,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_take,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_gc
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic addr_hit, addr_gc;
  logic [DATA_W-1:0] cand;

  tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tws_addr_dec #(.DATA_W(DATA_W), .RSV_BITS(RSV_BITS)) u_dec (
    .cand(cand), .own_addr(own_addr), .gc_en(gc_en), .busy(busy),
    .hit(addr_hit), .is_gc(addr_gc)
  );

  tws_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .addr_hit(addr_hit), .addr_gc(addr_gc),
    .tx_data(tx_data), .cand(cand), .sda_oe(sda_oe), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_gc(rx_gc)
  );
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              rx_valid,
  input logic              busy,
  input logic [DATA_W-1:0] cand,
  input logic              addr_hit
);
  a_r12_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r4_busy_refused: assert property (@(posedge clk) disable iff (rst)
    busy |-> !addr_hit);
  a_r7_gc_read_refused: assert property (@(posedge clk) disable iff (rst)
    (cand[DATA_W-1:1] == '0 && cand[0]) |-> !addr_hit);
  a_r8_reserved_refused: assert property (@(posedge clk) disable iff (rst)
    (&cand[DATA_W-1:DATA_W-4]) |-> !addr_hit);
endmodule

bind tws_slave tws_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .rx_valid(rx_valid),
  .busy(busy), .cand(cand), .addr_hit(addr_hit)
);

// File: tb/sim_tws_slave.sv
module sim_tws_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam logic [6:0] OWN = 7'h2C;

  logic clk = 0, rst = 1;
  logic m_scl = 1, m_sda = 1;
  logic [6:0] own_addr = OWN;
  logic gc_en = 0, busy = 0;
  logic [7:0] tx_data;
  logic sda_oe, tx_take, rx_valid, rx_gc;
  logic [7:0] rx_data;
  wire  bus_sda = m_sda & ~sda_oe;

  int n_run = 0, n_fail = 0;
  int rx_cnt = 0, take_cnt = 0;
  logic [7:0] last_rx;
  logic last_gc;
  logic [7:0] src [4] = '{8'hA5, 8'h3C, 8'h0F, 8'hF0};
  int idx = 0;

  always #(CLK_P/2) clk = ~clk;
  assign tx_data = src[idx % 4];

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_data; last_gc <= rx_gc; end
    if (tx_take) begin take_cnt <= take_cnt + 1; idx <= idx + 1; end
  end

  tws_slave u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
    .own_addr(own_addr), .gc_en(gc_en), .busy(busy), .tx_data(tx_data),
    .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid), .rx_gc(rx_gc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1; wt(Q); m_scl = 1; wt(Q); m_sda = 0; wt(Q); m_scl = 0; wt(Q);
  endtask

  task automatic bstop();
    m_sda = 0; wt(Q); m_scl = 1; wt(Q); m_sda = 1; wt(Q);
  endtask

  task automatic bbit(input logic b, output logic seen);
    m_sda = b; wt(Q); m_scl = 1; wt(Q); seen = bus_sda; wt(Q); m_scl = 0; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bbit(v[i], s);
    bbit(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bbit(1'b1, s); v[i] = s; end
    bbit(!mack, s);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_take", tx_take, 0);
  endtask

  task automatic t_own_write();
    logic a; int c0 = rx_cnt;
    bstart(); wbyte({OWN, 1'b0}, a); chk("R2 own ack", a, 1);
    wbyte(8'h5A, a); chk("R5 data ack", a, 1);
    chk("R5 byte", last_rx, 8'h5A); chk("R6 gc flag clear", last_gc, 0);
    wbyte(8'hC3, a); chk("R5 second byte", last_rx, 8'hC3);
    chk("R5 count", rx_cnt - c0, 2); bstop();
  endtask

  task automatic t_other();
    logic a; int c0 = rx_cnt;
    bstart(); wbyte({7'h2D, 1'b0}, a); chk("R3 nack", a, 0);
    wbyte(8'h11, a); chk("R3 data ignored ack", a, 0);
    chk("R3 no delivery", rx_cnt - c0, 0); bstop();
  endtask

  task automatic t_busy();
    logic a;
    busy = 1; bstart(); wbyte({OWN, 1'b0}, a); chk("R4 busy nack", a, 0);
    bstop(); busy = 0;
  endtask

  task automatic t_gc();
    logic a;
    gc_en = 0; bstart(); wbyte(8'h00, a); chk("R6 gc disabled nack", a, 0); bstop();
    gc_en = 1; bstart(); wbyte(8'h00, a); chk("R6 gc ack", a, 1);
    wbyte(8'h77, a); chk("R6 gc byte", last_rx, 8'h77); chk("R6 gc flag", last_gc, 1); bstop();
    bstart(); wbyte(8'h01, a); chk("R7 gc read nack", a, 0); bstop();
    gc_en = 0;
  endtask

  task automatic t_reserved();
    logic a;
    own_addr = 7'h7A; bstart(); wbyte({7'h7A, 1'b0}, a); chk("R8 reserved nack", a, 0);
    bstop(); own_addr = OWN;
  endtask

  task automatic t_read();
    logic a; logic [7:0] v; int t0;
    idx = 0; wt(2); t0 = take_cnt;
    bstart(); wbyte({OWN, 1'b1}, a); chk("R2 read ack", a, 1);
    rbyte(1'b1, v); chk("R9 first byte", v, 8'hA5);
    rbyte(1'b0, v); chk("R9 second byte", v, 8'h3C);
    chk("R9 take count", take_cnt - t0, 2);
    rbyte(1'b0, v); chk("R10 released after nack", v, 8'hFF);
    chk("R10 no more takes", take_cnt - t0, 2); bstop();
  endtask

  task automatic t_abort();
    logic a, s; int c0;
    bstart(); wbyte({OWN, 1'b0}, a);
    c0 = rx_cnt;
    for (int i = 0; i < 4; i++) bbit(1'b1, s);
    bstop(); chk("R11 stop drops partial", rx_cnt - c0, 0);
    bstart(); wbyte({OWN, 1'b0}, a);
    for (int i = 0; i < 3; i++) bbit(1'b0, s);
    bstart(); wbyte({7'h13, 1'b0}, a); chk("R11 restart other nack", a, 0);
    bstart(); wbyte({OWN, 1'b0}, a); chk("R11 restart own ack", a, 1);
    chk("R11 no partial delivered", rx_cnt - c0, 0); bstop();
  endtask

  initial begin
    wt(4); t_reset(); rst = 0; wt(4);
    t_own_write(); t_other(); t_busy(); t_gc(); t_reserved(); t_read(); t_abort();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule